// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector

This block compares two single-bit edge streams and produces the correction pulses for a charge pump. One stream is the reference and the other is the divided-down oscillator feedback. Both inputs are sampled by a fast system clock, and rising edges are found inside the block. A reference edge raises an "up" request and a feedback edge raises a "down" request. When both requests are set, both are withdrawn, so the width of the surviving pulse measures the phase lead of one stream over the other. A frequency difference shows up as pulses on one output only.

A programmable stretch keeps both outputs high for `MIN_PW` extra system-clock cycles whenever the two requests meet. Near lock, both outputs then pulse together on every cycle, which removes the dead zone of the comparison. While the stretch runs, newly arriving edges are discarded. The block also encodes a three-state pump command (neutral, raise, lower) from the two outputs, for a pump that takes a single steering code.

Top module: `phase_freq_cmp`

## Requirements
- R1: Only a rising edge acts on an input. A 0-to-1 change between two consecutive samples is an edge, and an input held high, or with any duty cycle, causes no further action.
- R2: If no stretch is running, a reference edge makes `up_o` high from the next clock on, and a feedback edge makes `dn_o` high from the next clock on. Each request stays high until it is cleared.
- R3: When both requests would be set, both are cleared. With `MIN_PW` = 0, `up_o` and `dn_o` are never high in the same cycle. With any `MIN_PW`, both are high together for at most `MIN_PW` consecutive cycles.
- R4: Edges on both inputs in the same sample cause no net request. With `MIN_PW` = 0 both outputs stay low. Otherwise both go high together for `MIN_PW` cycles. In both cases the pump command stays neutral.
- R5: With `MIN_PW` = 0, a reference faster than the feedback gives pulses only on `up_o`, and a faster feedback gives pulses only on `dn_o`.
- R6: For equal frequencies, the leading output's pulse is as wide as the lead, across a lead of up to one full input period. A feedback leading by half a period gives `dn_o` high for exactly half of each period.
- R7: With `MIN_PW` > 0, the clock that would set the second request instead raises both outputs. It holds both high for exactly `MIN_PW` cycles, then clears both. The leading output's pulse is therefore the lead plus `MIN_PW`, and the lagging output's pulse is `MIN_PW`.
- R8: Edges that arrive while a stretch is running are discarded and set no request.
- R9: `pump_cmd_o` is 2'b01 (raise) when only `up_o` is high and 2'b10 (lower) when only `dn_o` is high. It is 2'b00 (neutral) when the two outputs are equal, and it never takes the value 2'b11.
- R10: A synchronous active-high `rst` clears both outputs and any running stretch. During reset the edge detectors track the input level, so an input that is already high when reset is released is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference edge stream, sampled level |
| fbk_in | input | 1 | Feedback edge stream, sampled level |
| up_o | output | 1 | Up correction pulse |
| dn_o | output | 1 | Down correction pulse |
| pump_cmd_o | output | 2 | Pump steering code: 00 neutral, 01 raise, 10 lower |

## Verification
Single edge pairs with the reference leading, the feedback leading, and both in the same sample separate the set path, the coincident clear and the stretch. Each pattern is run on a zero-stretch instance and a stretched instance side by side. A sequence that places a reference edge inside a running stretch shows that the edge is discarded: a later feedback edge then raises only the down output. Periodic streams with unequal frequencies show the single-sided pulsing. Equal-period streams with a half-period and a near-full-period lead, and with very different duty cycles, check the pulse width against the lead and confirm that duty cycle has no effect.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   typedef enum logic [1:0] {
      PUMP_IDLE  = 2'b00,
      PUMP_RAISE = 2'b01,
      PUMP_LOWER = 2'b10
   } pump_cmd_e;

   localparam int NUM_CH = 2;
   localparam int CH_REF = 0;
   localparam int CH_FBK = 1;

endpackage

// File: rtl/pfc_rise_det.sv
module pfc_rise_det (
   input  logic clk,
   input  logic lvl_i,
   output logic rise_o
);

   logic prev_q;

   // Tracks the level in every cycle, reset included, so a level that is
   // already high when reset drops is not seen as an edge.
   always_ff @(posedge clk) begin
      prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/pfc_clear_timer.sv
module pfc_clear_timer #(
   parameter int MIN_PW = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   output logic hold_o,
   output logic rel_o
);

   localparam int CNT_W = (MIN_PW < 2) ? 1 : $clog2(MIN_PW + 1);

   generate
      if (MIN_PW == 0) begin : g_off
         logic unused_tie;
         assign unused_tie = start_i ^ clk ^ rst;
         assign hold_o     = 1'b0;
         assign rel_o      = 1'b0;
      end else begin : g_on
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end else if (start_i) begin
               cnt_q <= CNT_W'(MIN_PW);
            end
         end

         assign hold_o = (cnt_q != '0);
         assign rel_o  = (cnt_q == CNT_W'(1));
      end
   endgenerate

endmodule

// File: rtl/pfc_flag_core.sv
module pfc_flag_core #(
   parameter int MIN_PW = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_rise_i,
   input  logic fbk_rise_i,
   input  logic hold_i,
   input  logic rel_i,
   output logic meet_o,
   output logic up_o,
   output logic dn_o
);

   localparam bit STRETCH = (MIN_PW > 0);

   logic up_q, dn_q;
   logic up_nx, dn_nx;

   assign up_nx  = up_q | ref_rise_i;
   assign dn_nx  = dn_q | fbk_rise_i;
   assign meet_o = up_nx & dn_nx & ~hold_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (hold_i) begin
         if (rel_i) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
         end
      end else if (meet_o) begin
         up_q <= STRETCH;
         dn_q <= STRETCH;
      end else begin
         up_q <= up_nx;
         dn_q <= dn_nx;
      end
   end

   assign up_o = up_q;
   assign dn_o = dn_q;

endmodule

// File: rtl/pfc_cmd_enc.sv
module pfc_cmd_enc
   import pfc_pkg::*;
(
   input  logic       up_i,
   input  logic       dn_i,
   output logic [1:0] cmd_o
);

   pump_cmd_e cmd;

   always_comb begin
      unique case ({dn_i, up_i})
         2'b01:   cmd = PUMP_RAISE;
         2'b10:   cmd = PUMP_LOWER;
         default: cmd = PUMP_IDLE;
      endcase
   end

   assign cmd_o = cmd;

endmodule

// File: rtl/phase_freq_cmp.sv
module phase_freq_cmp
   import pfc_pkg::*;
#(
   parameter int MIN_PW = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ref_in,
   input  logic       fbk_in,
   output logic       up_o,
   output logic       dn_o,
   output logic [1:0] pump_cmd_o
);

   generate
      if (MIN_PW < 0 || MIN_PW > 65535) begin : g_bad_min_pw
         $error("phase_freq_cmp: MIN_PW must lie in 0..65535");
      end
   endgenerate

   logic [NUM_CH-1:0] lvl;
   logic [NUM_CH-1:0] rise;
   logic              ref_rise, fbk_rise;
   logic              hold, rel, meet;

   assign lvl[CH_REF] = ref_in;
   assign lvl[CH_FBK] = fbk_in;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_edge
         pfc_rise_det u_det (
            .clk    (clk),
            .lvl_i  (lvl[ch]),
            .rise_o (rise[ch])
         );
      end
   endgenerate

   assign ref_rise = rise[CH_REF];
   assign fbk_rise = rise[CH_FBK];

   pfc_clear_timer #(.MIN_PW(MIN_PW)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start_i (meet),
      .hold_o  (hold),
      .rel_o   (rel)
   );

   pfc_flag_core #(.MIN_PW(MIN_PW)) u_core (
      .clk        (clk),
      .rst        (rst),
      .ref_rise_i (ref_rise),
      .fbk_rise_i (fbk_rise),
      .hold_i     (hold),
      .rel_i      (rel),
      .meet_o     (meet),
      .up_o       (up_o),
      .dn_o       (dn_o)
   );

   pfc_cmd_enc u_enc (
      .up_i  (up_o),
      .dn_i  (dn_o),
      .cmd_o (pump_cmd_o)
   );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
   parameter int MIN_PW = 2
) (
   input logic       clk,
   input logic       rst,
   input logic       up_o,
   input logic       dn_o,
   input logic [1:0] pump_cmd_o,
   input logic       ref_rise,
   input logic       fbk_rise,
   input logic       hold
);

   localparam int RW  = $clog2(MIN_PW + 2);
   localparam int SAT = MIN_PW + 1;

   logic [RW-1:0] both_run, up_run, dn_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         both_run <= '0;
         up_run   <= '0;
         dn_run   <= '0;
      end else begin
         if (up_o && dn_o) begin
            if (int'(both_run) != SAT) both_run <= both_run + RW'(1);
         end else begin
            both_run <= '0;
         end
         if (up_o) begin
            if (int'(up_run) != SAT) up_run <= up_run + RW'(1);
         end else begin
            up_run <= '0;
         end
         if (dn_o) begin
            if (int'(dn_run) != SAT) dn_run <= dn_run + RW'(1);
         end else begin
            dn_run <= '0;
         end
      end
   end

   // R3: both outputs high together for no more than MIN_PW cycles
   a_r3_both_high_bounded: assert property (@(posedge clk) disable iff (rst)
      (up_o && dn_o) |-> (int'(both_run) < MIN_PW));

   // R7: every pulse lasts at least MIN_PW cycles
   a_r7_up_min_width: assert property (@(posedge clk) disable iff (rst)
      $fell(up_o) |-> (int'(up_run) >= MIN_PW));

   a_r7_dn_min_width: assert property (@(posedge clk) disable iff (rst)
      $fell(dn_o) |-> (int'(dn_run) >= MIN_PW));

   // R2: an edge outside a stretch sets its request
   a_r2_ref_sets_up: assert property (@(posedge clk) disable iff (rst)
      (ref_rise && !fbk_rise && !hold && !dn_o) |=> up_o);

   a_r2_fbk_sets_dn: assert property (@(posedge clk) disable iff (rst)
      (fbk_rise && !ref_rise && !hold && !up_o) |=> dn_o);

   // R1: no up request appears without a reference edge
   a_r1_up_needs_edge: assert property (@(posedge clk) disable iff (rst)
      !ref_rise |=> !$rose(up_o));

   // R8: nothing rises while a stretch runs
   a_r8_hold_frozen: assert property (@(posedge clk) disable iff (rst)
      hold |=> (!$rose(up_o) && !$rose(dn_o)));

   // R9: the steering code never takes the unused value
   a_r9_cmd_legal: assert property (@(posedge clk) disable iff (rst)
      pump_cmd_o != 2'b11);

endmodule

bind phase_freq_cmp pfc_checker #(.MIN_PW(MIN_PW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .up_o       (up_o),
   .dn_o       (dn_o),
   .pump_cmd_o (pump_cmd_o),
   .ref_rise   (ref_rise),
   .fbk_rise   (fbk_rise),
   .hold       (hold)
);

// File: tb/sim_phase_freq_cmp.sv
`timescale 1ns/1ps
module sim_phase_freq_cmp;

   localparam int PER = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ref_s = 1'b0;
   logic fbk_s = 1'b0;
   logic       up_a, dn_a, up_b, dn_b;
   logic [1:0] cmd_a, cmd_b;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   int   q_due[$];
   logic [3:0] q_exp[$];
   string q_tag[$];

   always #(PER/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // u0 stretched, u1 without stretch
   phase_freq_cmp #(.MIN_PW(2)) u0 (
      .clk(clk), .rst(rst), .ref_in(ref_s), .fbk_in(fbk_s),
      .up_o(up_a), .dn_o(dn_a), .pump_cmd_o(cmd_a));

   phase_freq_cmp #(.MIN_PW(0)) u1 (
      .clk(clk), .rst(rst), .ref_in(ref_s), .fbk_in(fbk_s),
      .up_o(up_b), .dn_o(dn_b), .pump_cmd_o(cmd_b));

   function automatic logic [1:0] cmd_of(input logic u, input logic d);
      // R9 encoding: 01 raise, 10 lower, 00 neutral
      if (u && !d) return 2'b01;
      if (d && !u) return 2'b10;
      return 2'b00;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (q_due.size() > 0 && q_due[0] <= cyc) begin
         logic [3:0] e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         void'(q_due.pop_front());
         chk({t, " u0 up/dn"}, {up_a, dn_a}, e[3:2]);
         chk({t, " u1 up/dn"}, {up_b, dn_b}, e[1:0]);
         chk("R9 u0 cmd", cmd_a, cmd_of(e[3], e[2]));
         chk("R9 u1 cmd", cmd_b, cmd_of(e[1], e[0]));
      end
   end

   task automatic push(input logic [3:0] e, input string tag);
      q_due.push_back(cyc + 1);
      q_exp.push_back(e);
      q_tag.push_back(tag);
   endtask

   task automatic put(input logic r, input logic f, input logic au, input logic ad,
                      input logic bu, input logic bd, input string tag);
      @(posedge clk); #(PER/4);
      rst = 1'b0; ref_s = r; fbk_s = f;
      push({au, ad, bu, bd}, tag);
   endtask

   task automatic do_reset(input logic r);
      for (int k = 0; k < 2; k++) begin
         @(posedge clk); #(PER/4);
         rst = 1'b1; ref_s = r; fbk_s = 1'b0;
         push(4'b0000, "R10");
      end
   endtask

   int n_au, n_ad, n_bu, n_bd, n_blow;

   task automatic periodic(input int rp, input int rh, input int ro,
                           input int fp, input int fh, input int fo, input int n);
      n_au = 0; n_ad = 0; n_bu = 0; n_bd = 0; n_blow = 0;
      for (int i = 0; i <= n; i++) begin
         @(posedge clk); #(PER/4);
         rst = 1'b0;
         if (i > 0) begin
            n_au += int'(up_a); n_ad += int'(dn_a);
            n_bu += int'(up_b); n_bd += int'(dn_b);
            if (cmd_b == 2'b10) n_blow++;
         end
         if (i < n) begin
            ref_s = (i >= ro) && (((i - ro) % rp) < rh);
            fbk_s = (i >= fo) && (((i - fo) % fp) < fh);
         end else begin
            ref_s = 1'b0; fbk_s = 1'b0;
         end
      end
   endtask

   initial begin
      #(PER * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0);

      // reference leads by three cycles
      put(1,0, 1,0, 1,0, "R2");
      put(1,0, 1,0, 1,0, "R1");
      put(0,0, 1,0, 1,0, "R2");
      put(0,1, 1,1, 0,0, "R3");
      put(0,1, 1,1, 0,0, "R7");
      put(0,0, 0,0, 0,0, "R7");
      put(0,0, 0,0, 0,0, "R3");

      // feedback leads by two cycles
      put(0,1, 0,1, 0,1, "R2");
      put(0,0, 0,1, 0,1, "R2");
      put(1,0, 1,1, 0,0, "R3");
      put(1,0, 1,1, 0,0, "R7");
      put(0,0, 0,0, 0,0, "R7");

      // same-sample edges, then held high
      put(1,1, 1,1, 0,0, "R4");
      put(1,1, 1,1, 0,0, "R4");
      put(1,1, 0,0, 0,0, "R1");
      put(0,0, 0,0, 0,0, "R4");

      // reference edge inside a running stretch is discarded on u0
      do_reset(1'b0);
      put(1,0, 1,0, 1,0, "R2");
      put(0,0, 1,0, 1,0, "R2");
      put(0,1, 1,1, 0,0, "R3");
      put(1,0, 1,1, 1,0, "R8");
      put(0,0, 0,0, 1,0, "R8");
      put(0,0, 0,0, 1,0, "R8");
      put(0,1, 0,1, 0,0, "R8");

      // reference high across reset release is not an edge
      do_reset(1'b1);
      put(1,0, 0,0, 0,0, "R10");
      put(0,0, 0,0, 0,0, "R10");
      put(1,0, 1,0, 1,0, "R1");
      do_reset(1'b0);
      repeat (3) @(posedge clk);

      // equal periods, feedback leads half a period, very unequal duty
      periodic(8, 1, 4, 8, 6, 0, 80);
      chk("R6 u1 dn cycles", n_bd, 40);
      chk("R6 u1 up cycles", n_bu, 0);
      chk("R7 u0 dn cycles", n_ad, 60);
      chk("R7 u0 up cycles", n_au, 20);
      chk("R9 u1 lower cycles", n_blow, 40);

      // lead of seven cycles in an eight-cycle period
      do_reset(1'b0);
      periodic(8, 4, 0, 8, 4, 7, 80);
      chk("R6 u1 up near full period", n_bu, 70);
      chk("R6 u1 dn near full period", n_bd, 0);

      // reference faster than feedback
      do_reset(1'b0);
      periodic(4, 2, 0, 6, 3, 1, 120);
      chk("R5 ref fast u1 dn", n_bd, 0);
      chk("R5 ref fast u1 up seen", int'(n_bu > 0), 1);

      // feedback faster than reference
      do_reset(1'b0);
      periodic(6, 3, 1, 4, 2, 0, 120);
      chk("R5 fbk fast u1 up", n_bu, 0);
      chk("R5 fbk fast u1 dn seen", int'(n_bd > 0), 1);

      do_reset(1'b0);
      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule